// File: doc/BRIEF.md
# Bit-Error Receiver: Pattern Lock and Error Tally

This block is the receive half of a bit-error tester. It takes one serial bit per strobed cycle, either from the line input or, in loopback, from the local transmit stream. It locks a reference pattern to that stream and compares each received bit against the reference. While locked it tallies every compared bit and every errored bit. The reference can be a pseudorandom sequence (x^15 + x^14 + 1) or a fixed word that repeats. Before lock, the reference is seeded from the received bits themselves. After lock it runs on its own, so a line error is never copied into it.

Software or a pin reads the result with a latch request. On the request's rising edge, the running tallies move into output registers and the running counters start again from zero. A second request copies the most recent received bits into a snapshot register. Lock is lost automatically when errors come too densely, unless that feature is switched off. Lock can also be thrown away on demand with a resync request.

Top module: `bert_rx`

## Requirements
- R1: After reset, `bit_count`, `err_count`, `rx_pattern` and `in_sync` are all zero.
- R2: While hunting, the reference bit is derived from earlier source bits. With `pat_rand`=1 it is the bit 15 positions back XOR the bit 14 positions back. With `pat_rand`=0 it is the bit 16 positions back. `in_sync` rises at the clock edge of the 32nd consecutive matching strobed bit, so a correctly filled reference locks in exactly 32 bits.
- R3: A strobed bit is counted only while `in_sync` is high. It adds one to the bit tally, and it adds one to the error tally when it differs from the reference. Once locked, the reference advances from its own prediction and not from received bits.
- R4: A rising edge of (`lc_bit` OR `lc_pin`) copies both running tallies to `bit_count` and `err_count` and restarts the running tallies at zero. When the request is low, both outputs hold.
- R5: A request that stays high latches only once. If the bit stays high, raising the pin causes no new latch. The OR must fall before another latch can occur.
- R6: The running tallies stop at all ones (255 with an 8-bit count width) and never wrap.
- R7: A rising edge of (`rl_bit` OR `rl_pin`) copies the last 32 source bits into `rx_pattern`, with the most recent bit in bit 0. Otherwise `rx_pattern` holds.
- R8: With `auto_dis`=0, the 6th errored bit inside one 64-bit window drops `in_sync` at that bit's clock edge. That bit is still counted. Windows start at lock.
- R9: The error count of a window clears at the window's end, so errors split across two windows (4 and 2) keep lock.
- R10: With `auto_dis`=1, errors never drop lock, even when every bit is in error.
- R11: A rising edge of `resync_bit` clears `in_sync` at that edge and restarts the hunt. A level that stays high does nothing more.
- R12: With `loop_en`=1, the source is `tx_loop_data` and `rx_data` has no effect on lock, tallies or snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Strobe: one source bit is taken this cycle |
| rx_data | input | 1 | Line receive bit |
| tx_loop_data | input | 1 | Local transmit bit, used in loopback |
| loop_en | input | 1 | 1 selects `tx_loop_data` as the source |
| pat_rand | input | 1 | 1 = pseudorandom reference, 0 = repeating word |
| auto_dis | input | 1 | 1 disables automatic loss of lock |
| resync_bit | input | 1 | Rising edge forces a new hunt |
| lc_bit | input | 1 | Latch-count request, control bit |
| lc_pin | input | 1 | Latch-count request, pin |
| rl_bit | input | 1 | Receive-snapshot request, control bit |
| rl_pin | input | 1 | Receive-snapshot request, pin |
| bit_count | output | CNT_W | Latched bit tally |
| err_count | output | CNT_W | Latched error tally |
| rx_pattern | output | SNAP_W | Latched snapshot of recent source bits |
| in_sync | output | 1 | Reference is locked |

## Verification
A fault in the hunt counter appears at `in_sync`. Lock would arrive earlier or later than the 32nd clean bit after a resync, and this is visible in the same cycle. A window-count or error-limit fault changes which injected error drops lock. Because counting stops at the drop, the next latch also reports a different bit tally. A fault in the tally counters or in the latch edge logic only appears at the next latch request. At that point the bit and error counts differ from the injected length and error count of the run.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;

   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_LOCK = 1'b1
   } lock_st_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bert_ref_pred.sv
module bert_ref_pred #(
   parameter int PRBS_LEN = 15,
   parameter int PRBS_TAP = 14,
   parameter int REP_LEN  = 16,
   parameter bit REP_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bit_in,
   input  logic rand_sel,
   input  logic lock,
   output logic pred
);
   localparam int HIST_W = bert_rx_pkg::max_int(PRBS_LEN, REP_EN ? REP_LEN : 2);

   logic [HIST_W-1:0] hist;
   logic              prbs_p;

   assign prbs_p = hist[PRBS_LEN-1] ^ hist[PRBS_TAP-1];

   generate
      if (REP_EN) begin : g_rep
         assign pred = rand_sel ? prbs_p : hist[REP_LEN-1];
      end else begin : g_prbs_only
         logic unused_sel;
         assign unused_sel = rand_sel;
         assign pred       = prbs_p;
      end
   endgenerate

   // Before lock the history fills from the line; after lock it free-runs.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (en) begin
         hist <= {hist[HIST_W-2:0], lock ? pred : bit_in};
      end
   end

endmodule

// File: rtl/bert_sync_ctl.sv
module bert_sync_ctl #(
   parameter int SYNC_LEN = 32,
   parameter int WIN_LEN  = 64,
   parameter int ERR_LIM  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic miss,
   input  logic auto_en,
   input  logic resync,
   output logic lock
);
   import bert_rx_pkg::*;

   localparam int MW = $clog2(SYNC_LEN + 1);
   localparam int WW = $clog2(WIN_LEN);
   localparam int EW = $clog2(ERR_LIM + 1);

   lock_st_e      st;
   logic [MW-1:0] mcnt;
   logic [WW-1:0] wpos;
   logic [EW-1:0] werr;
   logic [EW-1:0] werr_nx;

   assign lock    = (st == ST_LOCK);
   assign werr_nx = (miss && (werr != EW'(ERR_LIM))) ? werr + 1'b1 : werr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_HUNT;
         mcnt <= '0;
         wpos <= '0;
         werr <= '0;
      end else if (resync) begin
         st   <= ST_HUNT;
         mcnt <= '0;
         wpos <= '0;
         werr <= '0;
      end else if (en) begin
         if (st == ST_HUNT) begin
            if (miss) begin
               mcnt <= '0;
            end else if (mcnt == MW'(SYNC_LEN - 1)) begin
               st   <= ST_LOCK;
               mcnt <= '0;
               wpos <= '0;
               werr <= '0;
            end else begin
               mcnt <= mcnt + 1'b1;
            end
         end else begin
            if (auto_en && (werr_nx >= EW'(ERR_LIM))) begin
               st   <= ST_HUNT;
               wpos <= '0;
               werr <= '0;
            end else if (wpos == WW'(WIN_LEN - 1)) begin
               wpos <= '0;
               werr <= '0;
            end else begin
               wpos <= wpos + 1'b1;
               werr <= werr_nx;
            end
         end
      end
   end

endmodule

// File: rtl/bert_sat_cnt.sv
module bert_sat_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         take,
   output logic [W-1:0] held
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         held <= '0;
      end else if (take) begin
         held <= cnt;
         cnt  <= {{(W-1){1'b0}}, inc};
      end else if (inc && (cnt != {W{1'b1}})) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/bert_rx.sv
module bert_rx #(
   parameter int CNT_W    = 32,
   parameter int SNAP_W   = 32,
   parameter int SYNC_LEN = 32,
   parameter int WIN_LEN  = 64,
   parameter int ERR_LIM  = 6,
   parameter int PRBS_LEN = 15,
   parameter int PRBS_TAP = 14,
   parameter int REP_LEN  = 16,
   parameter bit REP_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              rx_data,
   input  logic              tx_loop_data,
   input  logic              loop_en,
   input  logic              pat_rand,
   input  logic              auto_dis,
   input  logic              resync_bit,
   input  logic              lc_bit,
   input  logic              lc_pin,
   input  logic              rl_bit,
   input  logic              rl_pin,
   output logic [CNT_W-1:0]  bit_count,
   output logic [CNT_W-1:0]  err_count,
   output logic [SNAP_W-1:0] rx_pattern,
   output logic              in_sync
);
   localparam int NCNT = 2;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (SNAP_W < 2) begin : g_bad_snap
         $error("SNAP_W must be at least 2");
      end
      if (SYNC_LEN < 2) begin : g_bad_sync
         $error("SYNC_LEN must be at least 2");
      end
      if ((PRBS_TAP < 1) || (PRBS_TAP >= PRBS_LEN)) begin : g_bad_tap
         $error("PRBS_TAP must lie below PRBS_LEN");
      end
      if ((ERR_LIM < 1) || (ERR_LIM > WIN_LEN) || (WIN_LEN < 2)) begin : g_bad_win
         $error("ERR_LIM must fit inside WIN_LEN");
      end
   endgenerate

   logic              src;
   logic              pred;
   logic              miss;
   logic              lock;
   logic              lc_d, rl_d, rs_d;
   logic              lc_edge, rl_edge, rs_edge;
   logic [SNAP_W-1:0] snap;
   logic [NCNT-1:0]   inc_v;
   logic [CNT_W-1:0]  held_v [NCNT];

   assign src     = loop_en ? tx_loop_data : rx_data;
   assign miss    = src ^ pred;
   assign lc_edge = (lc_bit | lc_pin) & ~lc_d;
   assign rl_edge = (rl_bit | rl_pin) & ~rl_d;
   assign rs_edge = resync_bit & ~rs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lc_d <= 1'b0;
         rl_d <= 1'b0;
         rs_d <= 1'b0;
      end else begin
         lc_d <= lc_bit | lc_pin;
         rl_d <= rl_bit | rl_pin;
         rs_d <= resync_bit;
      end
   end

   bert_ref_pred #(
      .PRBS_LEN (PRBS_LEN),
      .PRBS_TAP (PRBS_TAP),
      .REP_LEN  (REP_LEN),
      .REP_EN   (REP_EN)
   ) u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (bit_en),
      .bit_in   (src),
      .rand_sel (pat_rand),
      .lock     (lock),
      .pred     (pred)
   );

   bert_sync_ctl #(
      .SYNC_LEN (SYNC_LEN),
      .WIN_LEN  (WIN_LEN),
      .ERR_LIM  (ERR_LIM)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (bit_en),
      .miss    (miss),
      .auto_en (~auto_dis),
      .resync  (rs_edge),
      .lock    (lock)
   );

   assign inc_v[0] = bit_en & lock;
   assign inc_v[1] = bit_en & lock & miss;

   for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
      bert_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc_v[gi]),
         .take  (lc_edge),
         .held  (held_v[gi])
      );
   end

   assign bit_count = held_v[0];
   assign err_count = held_v[1];
   assign in_sync   = lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap       <= '0;
         rx_pattern <= '0;
      end else begin
         if (bit_en) begin
            snap <= {snap[SNAP_W-2:0], src};
         end
         if (rl_edge) begin
            rx_pattern <= snap;
         end
      end
   end

endmodule

// File: rtl/bert_rx_chk.sv
module bert_rx_chk #(
   parameter int CNT_W  = 32,
   parameter int SNAP_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              auto_dis,
   input logic              resync_bit,
   input logic              lc_bit,
   input logic              lc_pin,
   input logic              rl_bit,
   input logic              rl_pin,
   input logic [CNT_W-1:0]  bit_count,
   input logic [CNT_W-1:0]  err_count,
   input logic [SNAP_W-1:0] rx_pattern,
   input logic              in_sync
);
   logic rs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rs_q <= 1'b0;
      else        rs_q <= resync_bit;
   end

   // R4
   lc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lc_bit || lc_pin) |=> ($stable(bit_count) && $stable(err_count)));

   // R7
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rl_bit || rl_pin) |=> $stable(rx_pattern));

   // R10
   auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && auto_dis && !resync_bit) |=> in_sync);

   // R2
   hunt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_sync && !bit_en) |=> !in_sync);

   // R3
   err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_count <= bit_count);

   // R11
   resync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resync_bit && !rs_q) |=> !in_sync);

endmodule

bind bert_rx bert_rx_chk #(.CNT_W(CNT_W), .SNAP_W(SNAP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_en     (bit_en),
   .auto_dis   (auto_dis),
   .resync_bit (resync_bit),
   .lc_bit     (lc_bit),
   .lc_pin     (lc_pin),
   .rl_bit     (rl_bit),
   .rl_pin     (rl_pin),
   .bit_count  (bit_count),
   .err_count  (err_count),
   .rx_pattern (rx_pattern),
   .in_sync    (in_sync)
);

// File: tb/bert_rx_tb.sv
module bert_rx_tb;
   localparam int CW = 8;
   localparam int SW = 32;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, bit_en, rx_data, tx_loop_data, loop_en, pat_rand, auto_dis;
   logic          resync_bit, lc_bit, lc_pin, rl_bit, rl_pin;
   logic [CW-1:0] bit_count, err_count;
   logic [SW-1:0] rx_pattern;
   logic          in_sync;

   bert_rx #(.CNT_W(CW), .SNAP_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_data(rx_data),
      .tx_loop_data(tx_loop_data), .loop_en(loop_en), .pat_rand(pat_rand),
      .auto_dis(auto_dis), .resync_bit(resync_bit), .lc_bit(lc_bit),
      .lc_pin(lc_pin), .rl_bit(rl_bit), .rl_pin(rl_pin),
      .bit_count(bit_count), .err_count(err_count),
      .rx_pattern(rx_pattern), .in_sync(in_sync)
   );

   typedef struct packed {
      bit rnd; bit lp; bit adis;
      int nbits; int nerr; int first; int gap;
      int xbits; int xerrs; bit xsync;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 100,   0, 0,  1, 100,   0, 1'b1},  // R3 clean
      '{1'b1, 1'b0, 1'b0, 100,   3, 5,  7, 100,   3, 1'b1},  // R3 errors
      '{1'b0, 1'b0, 1'b0,  80,   2, 10, 30, 80,   2, 1'b1},  // R3 repeating word
      '{1'b1, 1'b0, 1'b0,  60,   6, 3, 10,  54,   6, 1'b0},  // R8 drop at 6th
      '{1'b1, 1'b0, 1'b0, 100,   5, 3, 10, 100,   5, 1'b1},  // R8 five keep lock
      '{1'b1, 1'b0, 1'b0, 120,   6, 3, 20, 120,   6, 1'b1},  // R9 split windows
      '{1'b1, 1'b0, 1'b1,  60,   6, 3, 10,  60,   6, 1'b1},  // R10 auto off
      '{1'b1, 1'b1, 1'b0, 100,   6, 3, 10, 100,   0, 1'b1},  // R12 loopback
      '{1'b1, 1'b0, 1'b1, 300, 300, 0,  1, 255, 255, 1'b1},  // R6 saturation
      '{1'b0, 1'b1, 1'b0,  50,   4, 2,  9,  50,   0, 1'b1}   // R12 loop, word
   };

   int            n_chk = 0;
   int            n_bad = 0;
   logic [14:0]   lfsr  = 15'h0001;
   logic [15:0]   rword = 16'hA5C3;
   logic [SW-1:0] snap_m = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic gen(output logic b);
      if (pat_rand) begin
         b    = lfsr[14] ^ lfsr[13];
         lfsr = {lfsr[13:0], b};
      end else begin
         b     = rword[15];
         rword = {rword[14:0], rword[15]};
      end
   endtask

   task automatic send(input logic flip);
      logic p;
      gen(p);
      bit_en       = 1'b1;
      tx_loop_data = loop_en ? p : ~p;
      rx_data      = loop_en ? (~p ^ flip) : (p ^ flip);
      snap_m       = {snap_m[SW-2:0], loop_en ? p : (p ^ flip)};
      @(negedge clk);
   endtask

   task automatic idle();
      bit_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic hunt(output int n);
      n = 0;
      while (!in_sync && n < 400) begin
         send(1'b0);
         n++;
      end
      bit_en = 1'b0;
   endtask

   task automatic latch();
      bit_en = 1'b0;
      lc_pin = 1'b1;
      @(negedge clk);
      lc_pin = 1'b0;
      @(negedge clk);
   endtask

   task automatic resync();
      bit_en     = 1'b0;
      resync_bit = 1'b1;
      @(negedge clk);
      chk("R11 lock cleared by resync edge", in_sync, 0);
      resync_bit = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog expired: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      int   n;
      int   k;
      logic f;
      logic [SW-1:0] saved;
      rst_n = 1'b0; bit_en = 1'b0; rx_data = 1'b0; tx_loop_data = 1'b0;
      loop_en = 1'b0; pat_rand = 1'b1; auto_dis = 1'b0; resync_bit = 1'b0;
      lc_bit = 1'b0; lc_pin = 1'b0; rl_bit = 1'b0; rl_pin = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bit_count", bit_count, 0);
      chk("R1 err_count", err_count, 0);
      chk("R1 rx_pattern", rx_pattern, 0);
      chk("R1 in_sync", in_sync, 0);

      for (int v = 0; v < NV; v++) begin
         pat_rand = VECS[v].rnd;
         loop_en  = VECS[v].lp;
         auto_dis = VECS[v].adis;
         resync();
         hunt(n);
         chk($sformatf("R2 lock reached, vector %0d", v), in_sync, 1);
         latch();
         k = 0;
         for (int i = 0; i < VECS[v].nbits; i++) begin
            f = (i >= VECS[v].first) && (((i - VECS[v].first) % VECS[v].gap) == 0)
                && (k < VECS[v].nerr);
            if (f) k++;
            send(f);
         end
         latch();
         chk($sformatf("R3 bit tally, vector %0d", v), bit_count, VECS[v].xbits);
         chk($sformatf("R3 error tally, vector %0d", v), err_count, VECS[v].xerrs);
         chk($sformatf("R8 lock state, vector %0d", v), in_sync, VECS[v].xsync);
      end

      // R2: with a valid reference, lock takes exactly 32 clean bits
      resync();
      hunt(n);
      chk("R2 bits to lock", n, 32);

      // R4 / R5: latch through the bit, then a pin edge under a high bit
      latch();
      for (int i = 0; i < 10; i++) send(1'b0);
      bit_en = 1'b0;
      lc_bit = 1'b1;
      @(negedge clk);
      chk("R4 latch through control bit", bit_count, 10);
      for (int i = 0; i < 7; i++) send(1'b0);
      bit_en = 1'b0;
      lc_pin = 1'b1;
      @(negedge clk);
      lc_pin = 1'b0;
      @(negedge clk);
      chk("R5 no relatch while request high", bit_count, 10);
      lc_bit = 1'b0;
      @(negedge clk);
      latch();
      chk("R5 relatch after request fell", bit_count, 7);
      chk("R5 error tally after relatch", err_count, 0);

      // R7 / R12: snapshot in loopback through the control bit
      for (int i = 0; i < 40; i++) send(1'b0);
      bit_en = 1'b0;
      rl_bit = 1'b1;
      @(negedge clk);
      chk("R12 snapshot takes loop source", rx_pattern, snap_m);
      saved = snap_m;
      for (int i = 0; i < 5; i++) send(1'b0);
      idle();
      chk("R7 snapshot holds while request high", rx_pattern, saved);
      rl_bit = 1'b0;
      idle();

      // R7: snapshot from line data through the pin, with flipped bits
      loop_en  = 1'b0;
      pat_rand = 1'b1;
      for (int i = 0; i < 32; i++) send((i % 5) == 1);
      bit_en = 1'b0;
      rl_pin = 1'b1;
      @(negedge clk);
      rl_pin = 1'b0;
      chk("R7 snapshot of last 32 line bits", rx_pattern, snap_m);
      idle();

      summary();
      $finish;
   end

endmodule